// File: doc/BRIEF.md
# Asynchronous Static Memory Access Controller

This block lets a synchronous on-chip requester read and write an external asynchronous static memory of 8192 bytes. The requester presents a request (valid, write flag, 13-bit address, 8-bit write data) and the controller accepts it when its ready output is high. A read returns one byte on a registered data output, marked by a single-cycle valid strobe.

On the memory side the controller drives the address pins, an active-low chip enable, an active-high second chip enable, an active-low write enable and an active-low output enable. The shared data bus is split into an output value, a driver enable and an input value, so that pad logic can join them. Every analog timing limit is a nanosecond parameter. Each limit is turned into a whole number of clock cycles by rounding up against the clock period parameter, with a floor of one cycle. Between accesses, and whenever the standby input is high, the memory is left deselected.

Top module: `sram_access_ctrl`

## Requirements
- R1: After a synchronous reset the memory pins are deselected (`mem_ce_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0), `req_ready` is 1 and `rsp_valid` is 0.
- R2: While no access is in progress the pins hold the deselected levels of R1. While `standby` is 1, `req_ready` is 0, a pending request is ignored, no write strobe occurs and no response is produced.
- R3: A read selects the memory (`mem_ce_n`=0, `mem_ce2`=1) with `mem_oe_n`=0 and `mem_we_n`=1. The data bus is sampled on the NR-th clock edge after the accepting edge, where NR = max(ceil(55/T), ceil(30/T)) and T is the clock period in ns. The sampled byte appears on `rsp_rdata` together with a `rsp_valid` pulse exactly one cycle long, seen NR+1 cycles after the request is presented.
- R4: The write strobe (`mem_we_n`=0) occurs only while the memory is selected and `mem_oe_n`=1. It lasts exactly NW consecutive cycles, where NW = max(ceil(45/T), ceil(25/T), ceil(50/T), ceil(55/T)-2, 1).
- R5: During a write, `mem_dq_oe` is 1 and `mem_dq_out` holds the requested byte, unchanged, from the cycle before the strobe falls through the cycle after it rises.
- R6: `mem_addr` is the same in the cycle before the strobe falls, in every strobe cycle, and in the cycle after it rises.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. It is raised only after `mem_oe_n` has been high for at least NH = ceil(20/T) cycles.
- R8: After a request is accepted, `req_ready` stays low for NR+NH cycles for a read and for NW+2 cycles for a write. A write produces no `rsp_valid`.
- R9: A read returns the byte last written to the same address, across addresses that exercise every address bit and across back-to-back read/write mixes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Hold the memory deselected and refuse new requests |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | 8 | Registered read byte |
| mem_addr | output | 13 | Memory address pins |
| mem_dq_out | output | 8 | Value to drive onto the memory data bus |
| mem_dq_oe | output | 1 | Enable for the controller's data bus drivers |
| mem_dq_in | input | 8 | Value seen on the memory data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Second chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
A corrupted sequencer state shows at the pins within one cycle: a strobe that is too short or too long, an address or data value that moves under the strobe, or drivers turned on against an enabled memory output. The bench watches all of these on every cycle. A wrong cycle count in the timer shifts the `rsp_valid` cycle and the length of the busy window, and both are measured on every access. A wrong capture or a wrong write path shows up as a read-back mismatch on the next read of that address.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_RREC,
    S_WSET,
    S_WSTB,
    S_WHLD
  } sac_state_e;

  // Whole cycles covering t_ns at period_ns, never fewer than one.
  function automatic int ns_to_cycles(input int t_ns, input int period_ns);
    int c;
    c = (t_ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold the value n.
  function automatic int bits_for(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/sac_timer.sv
module sac_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  // A loaded interval always ends in the idle value and never wraps.
  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && done) |=> done); // R3

endmodule

// File: rtl/sac_rdcap.sv
module sac_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      valid <= 1'b0;
    end else begin
      valid <= sample;
      if (sample) rdata <= bus_in;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R3

endmodule

// File: rtl/sac_fsm.sv
module sac_fsm
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2,
  parameter int N_RD   = 3,
  parameter int N_WS   = 3,
  parameter int N_HZ   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              t_done,
  output logic              t_load,
  output logic [CNT_W-1:0]  t_val,
  output logic              sample,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  localparam int RUN_MAX = max_int(N_WS, N_HZ) + 1;
  localparam int RUN_W   = bits_for(RUN_MAX);

  sac_state_e state;
  logic       accept;
  logic       rd_end;
  logic       ws_end;

  assign req_ready = (state == S_IDLE) && !standby;
  assign accept    = req_valid && req_ready;
  assign rd_end    = (state == S_RD) && t_done;
  assign ws_end    = (state == S_WSTB) && t_done;
  assign sample    = rd_end;

  // Interval loads: read access on accept, turnaround after a read,
  // strobe length while the write setup cycle runs.
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (accept && !req_write) begin
      t_load = 1'b1;
      t_val  = CNT_W'(N_RD - 1);
    end else if (rd_end) begin
      t_load = 1'b1;
      t_val  = CNT_W'(N_HZ - 1);
    end else if (state == S_WSET) begin
      t_load = 1'b1;
      t_val  = CNT_W'(N_WS - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      mem_ce_n   <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            mem_ce2  <= 1'b1;
            if (req_write) begin
              mem_dq_out <= req_wdata;
              mem_dq_oe  <= 1'b1;
              state      <= S_WSET;
            end else begin
              mem_oe_n <= 1'b0;
              state    <= S_RD;
            end
          end
        end
        S_RD: begin
          if (t_done) begin
            mem_oe_n <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_ce2  <= 1'b0;
            state    <= S_RREC;
          end
        end
        S_RREC: begin
          if (t_done) state <= S_IDLE;
        end
        S_WSET: begin
          mem_we_n <= 1'b0;
          state    <= S_WSTB;
        end
        S_WSTB: begin
          if (t_done) begin
            mem_we_n <= 1'b1;
            state    <= S_WHLD;
          end
        end
        S_WHLD: begin
          mem_ce_n  <= 1'b1;
          mem_ce2   <= 1'b0;
          mem_dq_oe <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Run-length monitors feeding the pin-timing properties.
  logic [RUN_W-1:0] oe_hi_run;
  logic [RUN_W-1:0] we_lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_hi_run <= RUN_W'(RUN_MAX);
      we_lo_run <= '0;
    end else begin
      if (!mem_oe_n) oe_hi_run <= '0;
      else if (oe_hi_run != RUN_W'(RUN_MAX)) oe_hi_run <= oe_hi_run + 1'b1;
      if (mem_we_n) we_lo_run <= '0;
      else if (we_lo_run != RUN_W'(RUN_MAX)) we_lo_run <= we_lo_run + 1'b1;
    end
  end

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2
  AST_STANDBY_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
    (standby && state == S_IDLE) |=> mem_ce_n); // R2
  AST_READ_PIN_LEVELS: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_ce2 && mem_we_n)); // R3
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_ce2 && mem_oe_n)); // R4
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_run == RUN_W'(N_WS))); // R4
  AST_WDATA_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe && $stable(mem_dq_out))); // R5
  AST_ADDR_STABLE_IN: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> $stable(mem_addr)); // R6
  AST_ADDR_STABLE_OUT: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> $stable(mem_addr)); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_hi_run >= RUN_W'(N_HZ))); // R7

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 20,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_OE_NS = 30,
  parameter int T_WP_NS = 45,
  parameter int T_WC_NS = 55,
  parameter int T_AW_NS = 50,
  parameter int T_DW_NS = 25,
  parameter int T_HZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  localparam int N_RD = max_int(max_int(ns_to_cycles(T_AA_NS, CLK_NS),
                                        ns_to_cycles(T_OE_NS, CLK_NS)),
                                ns_to_cycles(T_RC_NS, CLK_NS));
  localparam int N_WS = max_int(max_int(ns_to_cycles(T_WP_NS, CLK_NS),
                                        ns_to_cycles(T_DW_NS, CLK_NS)),
                                max_int(ns_to_cycles(T_AW_NS, CLK_NS),
                                        max_int(ns_to_cycles(T_WC_NS, CLK_NS) - 2, 1)));
  localparam int N_HZ = ns_to_cycles(T_HZ_NS, CLK_NS);
  localparam int CNT_W = bits_for(max_int(max_int(N_RD, N_WS), N_HZ));

  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_done;
  logic             sample;

  sac_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  sac_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .N_RD   (N_RD),
    .N_WS   (N_WS),
    .N_HZ   (N_HZ)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .standby    (standby),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .t_done     (t_done),
    .t_load     (t_load),
    .t_val      (t_val),
    .sample     (sample),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_ce_n   (mem_ce_n),
    .mem_ce2    (mem_ce2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n)
  );

  sac_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk    (clk),
    .rst    (rst),
    .sample (sample),
    .bus_in (mem_dq_in),
    .rdata  (rsp_rdata),
    .valid  (rsp_valid)
  );

  // Reads are only sampled while the memory is selected with outputs on.
  AST_SAMPLE_WHILE_ON: assert property (@(posedge clk) disable iff (rst)
    sample |-> (!mem_oe_n && !mem_ce_n && mem_ce2)); // R3

endmodule

// File: tb/tb_sram_access_ctrl.sv
module tb_sram_access_ctrl;
  localparam int TP = 20;

  function automatic int cyc(input int ns);
    int c;
    c = ns / TP;
    if (c * TP < ns) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD = mx(cyc(55), cyc(30));
  localparam int E_WS = mx(mx(cyc(45), cyc(25)), mx(cyc(50), mx(cyc(55) - 2, 1)));
  localparam int E_HZ = cyc(20);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in = 8'h00;
  logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n;

  always #(TP / 2) clk = ~clk;

  sram_access_ctrl dut (
    .clk(clk), .rst(rst), .standby(standby),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n),
    .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Memory model and pin monitor, evaluated between clock edges.
  logic [7:0] mdl [int unsigned];
  bit        mon_en = 0;
  bit        prev_we = 1;
  bit        prev_dq_oe = 0;
  int        we_lo = 0;
  int        oe_hi = 10;
  logic [12:0] prev_addr = '0;
  logic [12:0] s_addr = '0;
  logic [7:0]  s_data = '0;
  bit bad_addr = 0, bad_data = 0, bad_sel = 0, bad_cont = 0, bad_idle = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (!mem_we_n) begin
        if (prev_we) begin
          we_lo = 1;
          s_addr = mem_addr;
          s_data = mem_dq_out;
          chk(mem_addr == prev_addr, "R6 addr setup", int'(mem_addr), int'(prev_addr));
          if (!mem_dq_oe) bad_data = 1;
        end else begin
          we_lo++;
          if (mem_addr != s_addr) bad_addr = 1;
          if (mem_dq_out != s_data || !mem_dq_oe) bad_data = 1;
        end
        if (mem_ce_n || !mem_ce2 || !mem_oe_n) bad_sel = 1;
      end else if (!prev_we) begin
        chk(we_lo == E_WS, "R4 strobe width", we_lo, E_WS);
        chk(mem_addr == s_addr, "R6 addr hold", int'(mem_addr), int'(s_addr));
        chk(mem_dq_oe && mem_dq_out == s_data, "R5 data hold", int'(mem_dq_out), int'(s_data));
        mdl[int'(mem_addr)] = mem_dq_out;
      end
      if (mem_dq_oe && !mem_oe_n) bad_cont = 1;
      if (mem_dq_oe && !prev_dq_oe)
        chk(oe_hi >= E_HZ, "R7 turnaround", oe_hi, E_HZ);
      if (req_ready && (!mem_ce_n || mem_ce2 || !mem_we_n || !mem_oe_n || mem_dq_oe))
        bad_idle = 1;
      if (!mem_oe_n) oe_hi = 0;
      else if (oe_hi < 10) oe_hi++;
      if (!mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n)
        mem_dq_in <= mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 8'h00;
      else
        mem_dq_in <= 8'h00;
      prev_we = mem_we_n;
      prev_dq_oe = mem_dq_oe;
      prev_addr = mem_addr;
    end
  end

  // One access: present at a negedge, wait for acceptance, measure.
  task automatic access(input bit wr, input logic [12:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat, output int busy,
                        output int pulses);
    int k;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    k = 0; busy = 0; lat = -1; pulses = 0; rd = 8'h00;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      k++;
      if (rsp_valid) begin
        pulses++;
        if (lat < 0) begin lat = k; rd = rsp_rdata; end
      end
      if (!req_ready) busy++;
    end while (!req_ready);
    @(negedge clk);
    if (rsp_valid) pulses++;
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] rd; int lat, busy, pulses;
    access(1'b1, a, d, rd, lat, busy, pulses);
    chk(busy == E_WS + 2, "R8 write busy", busy, E_WS + 2);
    chk(pulses == 0, "R8 write no response", pulses, 0);
  endtask

  task automatic do_read(input logic [12:0] a, input logic [7:0] exp);
    logic [7:0] rd; int lat, busy, pulses;
    access(1'b0, a, 8'h00, rd, lat, busy, pulses);
    chk(lat == E_RD + 1, "R3 read latency", lat, E_RD + 1);
    chk(pulses == 1, "R3 valid pulse count", pulses, 1);
    chk(busy == E_RD + E_HZ, "R8 read busy", busy, E_RD + E_HZ);
    chk(rd == exp, "R9 read data", int'(rd), int'(exp));
  endtask

  function automatic logic [12:0] sweep_addr(input int i);
    return 13'((i << 5) | (i & 31));
  endfunction

  function automatic logic [7:0] sweep_data(input int i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(mem_ce_n == 1'b1, "R1 ce_n", int'(mem_ce_n), 1);
    chk(mem_ce2 == 1'b0, "R1 ce2", int'(mem_ce2), 0);
    chk(mem_we_n == 1'b1 && mem_oe_n == 1'b1, "R1 we_n/oe_n",
        int'({mem_we_n, mem_oe_n}), 3);
    chk(mem_dq_oe == 1'b0, "R1 dq_oe", int'(mem_dq_oe), 0);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready/valid",
        int'({req_ready, rsp_valid}), 2);
    mon_en = 1;

    // Sweep: writes then reads over addresses touching every address bit.
    for (int i = 0; i < 256; i++) do_write(sweep_addr(i), sweep_data(i));
    for (int i = 0; i < 256; i++) do_read(sweep_addr(i), sweep_data(i));

    // Corner patterns: extremes, overwrite, read-write-read back to back.
    do_write(13'h1FFF, 8'hFF);
    do_write(13'h0000, 8'h00);
    do_read(13'h1FFF, 8'hFF);
    do_read(13'h0000, 8'h00);
    do_write(13'h0000, 8'h5A);
    do_read(13'h0000, 8'h5A);
    do_write(13'h0AAA, 8'hC3);
    do_read(13'h0AAA, 8'hC3);
    do_write(13'h0AAA, 8'h3C);
    do_read(13'h0AAA, 8'h3C);

    // R2 standby: a write presented during standby must be ignored.
    begin
      bit sb_bad;
      sb_bad = 0;
      standby = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0AAA; req_wdata = 8'h99;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (req_ready || !mem_ce_n || mem_ce2 || !mem_we_n || rsp_valid) sb_bad = 1;
      end
      req_valid = 1'b0;
      @(negedge clk);
      standby = 1'b0;
      @(negedge clk);
      chk(!sb_bad, "R2 standby deselected", int'(sb_bad), 0);
      chk(req_ready == 1'b1, "R2 ready after standby", int'(req_ready), 1);
    end
    do_read(13'h0AAA, 8'h3C);  // R2: old value survives the ignored write

    chk(!bad_addr, "R6 addr moved in strobe", int'(bad_addr), 0);
    chk(!bad_data, "R5 data moved in strobe", int'(bad_data), 0);
    chk(!bad_sel, "R4 strobe outside select", int'(bad_sel), 0);
    chk(!bad_cont, "R7 bus contention", int'(bad_cont), 0);
    chk(!bad_idle, "R2 idle pins", int'(bad_idle), 0);
    finish_run();
  end

endmodule